// File: doc/BRIEF.md
# Context-Tagged Return Target Stack

This block predicts where a subroutine return will land. Each call writes its return address onto a small circular stack, and each return takes the newest entry off the stack as the predicted target. The stack holds a fixed number of entries. When calls nest deeper than that, the newest writes wrap around and replace the oldest entries without any signal, so the most recent frames are always kept.

Every entry also stores the execution-context identifier that was current when it was written. A return presents its own context identifier. If the popped entry belongs to another context, the prediction is marked invalid, although the entry is still removed. This stops one context from steering the returns of another. A barrier-flush input removes all stored state in one cycle. It is meant for transitions between mutually untrusted contexts.

The predicted address and its valid flag are registered. They appear in the cycle after the clock edge that samples the pop.

Top module: `ras_ctx_stack`

## Requirements
- R1: Reset is synchronous and active high. During and after reset, `pred_valid` is 0 and the stack is empty. A pop issued right after reset, or right after a reset applied mid-run, gives `pred_valid` = 0.
- R2: A pop against a non-empty stack is sampled at a clock edge. After that edge, `pred_addr` holds the address from the newest entry. `pred_valid` is 1 when the entry's stored context equals `pop_ctx`.
- R3: Entries come out in last-in-first-out order. The occupancy never exceeds DEPTH (16 by default).
- R4: A pop against an empty stack gives `pred_valid` = 0 and leaves the stack pointer unchanged. A following push and pop therefore return the pushed address.
- R5: After more than DEPTH pushes, the oldest entries are overwritten. DEPTH further pops return the newest DEPTH addresses in reverse order, and the next pop gives `pred_valid` = 0.
- R6: A pop whose entry carries a context tag different from `pop_ctx` gives `pred_valid` = 0 but still removes the entry. The next pop returns the entry below it.
- R7: A push and a pop in the same cycle on a non-empty stack predict the old top entry. The top entry is then replaced with the pushed address and context, and the depth stays the same. On an empty stack, the same combination behaves as a plain push and gives `pred_valid` = 0.
- R8: A flush empties the stack and clears every entry's valid bit. It takes priority over a push or pop in the same cycle, so a push made with a flush is discarded and a pop made with a flush gives `pred_valid` = 0.
- R9: `pred_valid` is 1 only in the cycle that follows a pop. In every cycle without a pop it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Call seen: store `push_addr` and `push_ctx` |
| push_addr | input | AW | Return address to store |
| push_ctx | input | CW | Context identifier of the caller |
| pop_en | input | 1 | Return seen: remove the newest entry and predict from it |
| pop_ctx | input | CW | Context identifier of the returning code |
| flush | input | 1 | Barrier: clear the whole stack |
| pred_addr | output | AW | Predicted return target (registered) |
| pred_valid | output | 1 | Prediction is usable (registered) |

## Verification
The hardest state to reach from the ports is a stack that has wrapped. The pointer has passed the oldest surviving entry, the occupancy is saturated, and the stack must unwind exactly DEPTH entries before it reports empty. The bench reaches this state by pushing DEPTH+1 distinct addresses in a row, then popping DEPTH+1 times, checking each address and then the final invalid pop. Context mismatch and the simultaneous push-and-pop are set up from known stack contents in the vector table, so the entry underneath the one being tested can be checked on the next pop.

// File: rtl/rasx_pkg.sv
package rasx_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/rasx_ptr.sv
module rasx_ptr #(
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic          pop_en,
  input  logic          flush,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic          rd_en,
  output logic [PW-1:0] rd_idx
);
  import rasx_pkg::*;

  logic [PW-1:0]   wr_ptr;
  logic [CNTW-1:0] occ;
  logic            nonempty;
  stk_op_e         op;

  always_comb begin
    nonempty = (occ != '0);
    rd_en    = pop_en && !flush && nonempty;
    wr_en    = push_en && !flush;
    unique case ({wr_en, rd_en})
      2'b10:   op = STK_PUSH;
      2'b01:   op = STK_POP;
      2'b11:   op = STK_SWAP;
      default: op = STK_IDLE;
    endcase
    rd_idx = wr_ptr - PW'(1);
    wr_idx = (op == STK_SWAP) ? rd_idx : wr_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      case (op)
        STK_PUSH: begin
          wr_ptr <= wr_ptr + PW'(1);
          if (occ != CNTW'(DEPTH)) occ <= occ + CNTW'(1);
        end
        STK_POP: begin
          wr_ptr <= rd_idx;
          occ    <= occ - CNTW'(1);
        end
        default: ;
      endcase
    end
  end

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
    occ <= CNTW'(DEPTH));

  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_en && !push_en && !flush && occ == '0) |=> ($stable(wr_ptr) && occ == '0));

  assert_swap_depth_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_en && push_en && !flush && occ != '0) |=> ($stable(wr_ptr) && $stable(occ)));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0 && wr_ptr == '0));
endmodule

// File: rtl/rasx_store.sv
module rasx_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int CW    = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_ctx,
  input  logic          rd_en,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr_q,
  output logic [CW-1:0] rd_ctx,
  output logic          rd_live
);
  logic [AW-1:0]    addr_mem [DEPTH];
  logic [CW-1:0]    ctx_tag  [DEPTH];
  logic [DEPTH-1:0] live;

  // address array: single write port, read-first registered read with enable
  always_ff @(posedge clk) begin
    if (wr_en) addr_mem[wr_idx] <= wr_addr;
    if (rd_en) rd_addr_q <= addr_mem[rd_idx];
  end

  // tags and valid bits in flops so that a flush clears them in one cycle
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      live <= '0;
    end else if (wr_en) begin
      live[wr_idx] <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_tag
      always_ff @(posedge clk) begin
        if (rst) ctx_tag[g] <= '0;
        else if (wr_en && wr_idx == PW'(g)) ctx_tag[g] <= wr_ctx;
      end
    end
  endgenerate

  always_comb begin
    rd_ctx  = ctx_tag[rd_idx];
    rd_live = live[rd_idx];
  end

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (live == '0));
endmodule

// File: rtl/rasx_match.sv
module rasx_match #(
  parameter int CW = 4
) (
  input  logic          rd_en,
  input  logic          entry_live,
  input  logic [CW-1:0] entry_ctx,
  input  logic [CW-1:0] cur_ctx,
  output logic          hit
);
  always_comb hit = rd_en && entry_live && (entry_ctx == cur_ctx);
endmodule

// File: rtl/ras_ctx_stack.sv
module ras_ctx_stack #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int CW    = 4,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic [AW-1:0] push_addr,
  input  logic [CW-1:0] push_ctx,
  input  logic          pop_en,
  input  logic [CW-1:0] pop_ctx,
  input  logic          flush,
  output logic [AW-1:0] pred_addr,
  output logic          pred_valid
);
  logic          wr_en, rd_en, rd_live, hit;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] rd_ctx;
  logic          valid_q;

  rasx_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .push_en(push_en), .pop_en(pop_en), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_en(rd_en), .rd_idx(rd_idx)
  );

  rasx_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(push_addr), .wr_ctx(push_ctx),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_addr_q(pred_addr), .rd_ctx(rd_ctx), .rd_live(rd_live)
  );

  rasx_match #(.CW(CW)) u_match (
    .rd_en(rd_en), .entry_live(rd_live), .entry_ctx(rd_ctx),
    .cur_ctx(pop_ctx), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= hit;
  end

  assign pred_valid = valid_q;

  assert_valid_after_pop_R9: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(pop_en));

  assert_flush_no_pred_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pred_valid);
endmodule

// File: tb/test_ras_ctx_stack.sv
module test_ras_ctx_stack;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int CW = 4;

  typedef struct packed {
    logic          psh;
    logic          pp;
    logic          fl;
    logic [AW-1:0] a;
    logic [CW-1:0] pc;
    logic [CW-1:0] cc;
    logic          ev;
    logic [AW-1:0] ea;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 32'd0,   4'd0, 4'd0, 1'b0, 32'd0},   // R4 empty pop
    '{1'b1, 1'b0, 1'b0, 32'd100, 4'd1, 4'd0, 1'b0, 32'd0},
    '{1'b1, 1'b0, 1'b0, 32'd200, 4'd1, 4'd0, 1'b0, 32'd0},
    '{1'b1, 1'b0, 1'b0, 32'd300, 4'd2, 4'd0, 1'b0, 32'd0},
    '{1'b0, 1'b1, 1'b0, 32'd0,   4'd0, 4'd2, 1'b1, 32'd300}, // R2
    '{1'b0, 1'b1, 1'b0, 32'd0,   4'd0, 4'd1, 1'b1, 32'd200}, // R3
    '{1'b1, 1'b1, 1'b0, 32'd400, 4'd1, 4'd1, 1'b1, 32'd100}, // R7 swap
    '{1'b0, 1'b1, 1'b0, 32'd0,   4'd0, 4'd1, 1'b1, 32'd400}, // R7 replaced
    '{1'b0, 1'b1, 1'b0, 32'd0,   4'd0, 4'd1, 1'b0, 32'd0},   // R7 depth same
    '{1'b1, 1'b0, 1'b0, 32'd500, 4'd3, 4'd0, 1'b0, 32'd0},
    '{1'b1, 1'b0, 1'b0, 32'd600, 4'd1, 4'd0, 1'b0, 32'd0},
    '{1'b0, 1'b1, 1'b0, 32'd0,   4'd0, 4'd3, 1'b0, 32'd0},   // R6 mismatch
    '{1'b0, 1'b1, 1'b0, 32'd0,   4'd0, 4'd3, 1'b1, 32'd500}, // R6 consumed
    '{1'b0, 1'b0, 1'b0, 32'd0,   4'd0, 4'd0, 1'b0, 32'd0},   // R9 idle
    '{1'b1, 1'b1, 1'b0, 32'd700, 4'd0, 4'd0, 1'b0, 32'd0},   // R7 empty swap
    '{1'b0, 1'b1, 1'b0, 32'd0,   4'd0, 4'd0, 1'b1, 32'd700}  // R7 acts as push
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          push_en, pop_en, flush;
  logic [AW-1:0] push_addr;
  logic [CW-1:0] push_ctx, pop_ctx;
  logic [AW-1:0] pred_addr;
  logic          pred_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_ctx_stack #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_ras_ctx_stack (
    .clk(clk), .rst(rst), .push_en(push_en), .push_addr(push_addr),
    .push_ctx(push_ctx), .pop_en(pop_en), .pop_ctx(pop_ctx), .flush(flush),
    .pred_addr(pred_addr), .pred_valid(pred_valid)
  );

  task automatic step(input logic ps, input logic pp, input logic fl,
                      input logic [AW-1:0] a, input logic [CW-1:0] pc,
                      input logic [CW-1:0] cc);
    push_en = ps; pop_en = pp; flush = fl;
    push_addr = a; push_ctx = pc; pop_ctx = cc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic ev, input logic [AW-1:0] ea);
    total++;
    if (pred_valid !== ev || (ev && pred_addr !== ea)) begin
      bad++;
      $display("FAIL %s: valid=%0b addr=%0d expected valid=%0b addr=%0d",
               req, pred_valid, pred_addr, ev, ea);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    push_en = 1'b0; pop_en = 1'b0; flush = 1'b0;
    push_addr = '0; push_ctx = '0; pop_ctx = '0;
    @(negedge clk);
    step(1'b0, 1'b0, 1'b0, '0, '0, '0);
    step(1'b0, 1'b0, 1'b0, '0, '0, '0);
    chk("R1 reset state", 1'b0, '0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].psh, VECS[i].pp, VECS[i].fl, VECS[i].a, VECS[i].pc, VECS[i].cc);
      chk($sformatf("R2/R3/R4/R6/R7/R9 vector %0d", i), VECS[i].ev, VECS[i].ea);
    end
    step(1'b0, 1'b0, 1'b0, '0, '0, '0);
    chk("R9 no pop no valid", 1'b0, '0);

    // R5 overflow: DEPTH+1 pushes, then unwind
    for (int i = 0; i <= DEPTH; i++)
      step(1'b1, 1'b0, 1'b0, AW'(1000 + i), 4'd5, '0);
    for (int i = DEPTH; i >= 1; i--) begin
      step(1'b0, 1'b1, 1'b0, '0, '0, 4'd5);
      chk("R5 wrap order", 1'b1, AW'(1000 + i));
    end
    step(1'b0, 1'b1, 1'b0, '0, '0, 4'd5);
    chk("R5 R3 saturated depth exhausted", 1'b0, '0);

    // R8 flush clears
    step(1'b1, 1'b0, 1'b0, 32'd42, 4'd2, '0);
    step(1'b1, 1'b0, 1'b0, 32'd43, 4'd2, '0);
    step(1'b0, 1'b0, 1'b1, '0, '0, '0);
    step(1'b0, 1'b1, 1'b0, '0, '0, 4'd2);
    chk("R8 flush empties", 1'b0, '0);
    // R8 flush beats push
    step(1'b1, 1'b0, 1'b1, 32'd77, 4'd2, '0);
    step(1'b0, 1'b1, 1'b0, '0, '0, 4'd2);
    chk("R8 push with flush dropped", 1'b0, '0);
    // R8 flush beats pop
    step(1'b1, 1'b0, 1'b0, 32'd88, 4'd2, '0);
    step(1'b0, 1'b1, 1'b1, '0, '0, 4'd2);
    chk("R8 pop with flush", 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0, '0, 4'd2);
    chk("R8 stack empty after flush", 1'b0, '0);

    // R1 mid-run reset
    step(1'b1, 1'b0, 1'b0, 32'd99, 4'd1, '0);
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0, '0, '0, '0);
    rst = 1'b0;
    step(1'b0, 1'b1, 1'b0, '0, '0, 4'd1);
    chk("R1 pop after reset", 1'b0, '0);
    // R4 pointer intact after empty pop
    step(1'b1, 1'b0, 1'b0, 32'd123, 4'd6, '0);
    step(1'b0, 1'b1, 1'b0, '0, '0, 4'd6);
    chk("R4 push after empty pop", 1'b1, 32'd123);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule